// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters, least significant bit first, against one serial clock shared by both directions. It adds no parity or address bit. The transmit side and the receive side each have a holding register and a shift register. Software can therefore queue the next byte while the current one shifts out, and can read the last byte while the next one arrives.

A select input picks the clock source. In internal mode a reloadable divider makes the serial clock and drives it out of the block. That clock rests high, gives eight pulses per character, and runs with no gap while the transmit holding register keeps refilling. In external mode the serial clock comes in from the pin through a two-flop synchronizer, and both shifters follow its edges. Transmit data changes on falling edges. Receive data is sampled on rising edges.

Both byte paths use valid/ready. A transmit byte is taken on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while the holding register is full, and it doubles as the data-empty flag. A received byte is offered with `rx_valid` and leaves on a clock where `rx_ready` is also high. The byte stays valid and stable for as long as `rx_ready` is low.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Each character is 8 bits shifted out on `txd` least significant bit first, with no extra bit before or after.
- R2: `txd` changes only in the cycle where the serial clock falls, and holds each bit until the next fall. After the last bit it keeps driving the MSB of that character.
- R3: `rxd` is sampled on each rising serial clock edge. The first bit sampled is the LSB of the assembled byte, and the byte appears on `rx_data` with `rx_valid` after the eighth sample.
- R4: In internal mode (`ext_sel`=0), `sck_oe` is 1 and `sck_o` rests at 1 while nothing is shifting. Each character makes exactly 8 low pulses, and each high phase and each low phase of a pulse lasts `div_reload`+1 system clocks.
- R5: If the transmit holding register is full when a character ends, the next character starts with no extra idle high time on the serial clock.
- R6: `tx_ready` is 1 exactly when the transmit holding register is empty. A byte offered while the previous one is shifting is accepted, and a third byte is refused until the holding register empties.
- R7: A received byte stays on `rx_data` with `rx_valid` high until it is taken with `rx_ready`. The next character can arrive during that time.
- R8: If a byte completes while `rx_valid` is high and no read happens in that cycle, `ovr_flag` is set and the new byte is dropped. `ovr_flag` stays 1 until a cycle with `ovr_clr` high.
- R9: In external mode (`ext_sel`=1), `sck_oe` is 0, `sck_o` is 1, and both shifters move only on edges of `sck_i` after synchronization. With no edges on `sck_i`, `txd` does not change.
- R10: Transmit and receive run at the same time on the same clock pulses, each with its own byte.
- R11: During reset, `tx_ready`=1, `rx_valid`=0, `ovr_flag`=0, `sck_o`=1 and `txd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_sel | input | 1 | 1 = external serial clock, 0 = internal divider |
| div_reload | input | DIV_W | Divider reload N; serial period is 2*(N+1) clocks |
| tx_data | input | CHAR_W | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | CHAR_W | Received byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes the received byte |
| ovr_flag | output | 1 | Sticky receive overrun |
| ovr_clr | input | 1 | Clears the overrun flag |
| sck_i | input | 1 | Serial clock from the pin (external mode) |
| sck_o | output | 1 | Serial clock to the pin (internal mode) |
| sck_oe | output | 1 | Drive enable for the clock pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The bench builds the block with its default parameters: 8-bit characters, an 8-bit divider and a two-stage synchronizer. It varies `div_reload` at run time between 0 and 3. A reload of 0 gives a serial period of two system clocks. At that rate the first transmit bit, the sample point of the last receive bit and the reload from the holding register all fall on neighbouring cycles. The continuous-transfer and overrun timing is therefore tested at its tightest. External mode is run with a slow bench-made clock, so the synchronizer delay sits well inside each half period.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Default character size and divider width shared by the block
  localparam int unsigned SST_CHAR_W = 8;
  localparam int unsigned SST_DIV_W  = 8;
  localparam int unsigned SST_SYNC_N = 2;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int unsigned DIV_W  = sst_pkg::SST_DIV_W,
  parameter int unsigned SYNC_N = sst_pkg::SST_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_reload,
  input  logic             run,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             fall_p,
  output logic             rise_p
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;
  logic [SYNC_N:0]  sync_q;   // [SYNC_N-1:0] synchronizer, [SYNC_N] previous value
  logic             ext_fall, ext_rise;

  // Internal half-period divider; parked with clock high when not running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (ext_sel || !run) begin
      cnt_q <= div_reload;
      sck_q <= 1'b1;
    end else if (cnt_q == '0) begin
      cnt_q <= div_reload;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = !ext_sel && run && (cnt_q == '0);

  // External clock synchronizer chain
  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[0], sck_i};
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-1:0], sck_i};
      end
    end
  endgenerate

  assign ext_fall = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];
  assign ext_rise = ~sync_q[SYNC_N] & sync_q[SYNC_N-1];

  assign fall_p = ext_sel ? ext_fall : (tick & sck_q);
  assign rise_p = ext_sel ? ext_rise : (tick & ~sck_q);
  assign sck_o  = ext_sel ? 1'b1 : sck_q;
  assign sck_oe = ~ext_sel;
endmodule

// File: rtl/sst_tx.sv
module sst_tx #(
  parameter int unsigned CHAR_W = sst_pkg::SST_CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              fall_p,
  input  logic              rise_p,
  output logic              txd,
  output logic              busy
);
  localparam int unsigned CW = $clog2(CHAR_W + 1);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W);

  logic [CHAR_W-1:0] hold_q, shf_q;
  logic              hold_full;
  logic [CW-1:0]     fcnt_q;
  logic              busy_q, txd_q;
  logic              accept, done;

  assign accept = tx_valid && !hold_full;
  assign done   = busy_q && rise_p && (fcnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      shf_q     <= '0;
      fcnt_q    <= '0;
      busy_q    <= 1'b0;
      txd_q     <= 1'b1;
    end else begin
      if (accept) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if ((!busy_q || done) && hold_full) begin
        shf_q     <= hold_q;
        hold_full <= 1'b0;
        busy_q    <= 1'b1;
        fcnt_q    <= '0;
      end else if (done) begin
        busy_q    <= 1'b0;
      end else if (busy_q && fall_p && (fcnt_q != LAST)) begin
        txd_q  <= shf_q[0];
        shf_q  <= shf_q >> 1;
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  assign tx_ready = ~hold_full;
  assign txd      = txd_q;
  assign busy     = busy_q;
endmodule

// File: rtl/sst_rx.sv
module sst_rx #(
  parameter int unsigned CHAR_W = sst_pkg::SST_CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_p,
  input  logic              rxd,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              ovr_flag,
  input  logic              ovr_clr
);
  localparam int unsigned CW = $clog2(CHAR_W);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);

  logic [CHAR_W-1:0] shf_q, data_q, next_byte;
  logic [CW-1:0]     rcnt_q;
  logic              valid_q, ovr_q;
  logic              complete, pop, lost;

  assign next_byte = {rxd, shf_q[CHAR_W-1:1]};
  assign complete  = rise_p && (rcnt_q == LAST);
  assign pop       = valid_q && rx_ready;
  assign lost      = complete && valid_q && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q   <= '0;
      rcnt_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rise_p) begin
        shf_q  <= next_byte;
        rcnt_q <= complete ? '0 : rcnt_q + 1'b1;
      end
      if (complete && !lost) begin
        data_q  <= next_byte;
        valid_q <= 1'b1;
      end else if (pop) begin
        valid_q <= 1'b0;
      end
      if (lost)         ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int unsigned CHAR_W = sst_pkg::SST_CHAR_W,
  parameter int unsigned DIV_W  = sst_pkg::SST_DIV_W,
  parameter int unsigned SYNC_N = sst_pkg::SST_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sel,
  input  logic [DIV_W-1:0]  div_reload,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              ovr_flag,
  input  logic              ovr_clr,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              txd,
  input  logic              rxd
);
  logic fall_p, rise_p, tx_busy;

  sst_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .div_reload(div_reload),
    .run(tx_busy), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .fall_p(fall_p), .rise_p(rise_p)
  );

  sst_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .fall_p(fall_p), .rise_p(rise_p), .txd(txd),
    .busy(tx_busy)
  );

  sst_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
  );
endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_sel,
  input logic              busy,
  input logic              sck_o,
  input logic              txd,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [CHAR_W-1:0] rx_data,
  input logic              ovr_flag,
  input logic              ovr_clr
);
  // R4
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !busy) |-> sck_o);

  // R2
  txd_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !$stable(txd)) |-> $fell(sck_o));

  // R6
  tx_hold_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R7
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R8
  ovr_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> (rx_valid && $stable(rx_data)));
endmodule

bind sync_serial_xcvr sst_chk #(.CHAR_W(CHAR_W)) u_sst_chk (
  .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .busy(tx_busy),
  .sck_o(sck_o), .txd(txd), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
);

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int EXT_HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel = 1'b0;
  logic [DW-1:0] div_reload = '0;
  logic [CW-1:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [CW-1:0] rx_data;
  logic rx_valid, rx_ready = 1'b1;
  logic ovr_flag, ovr_clr = 1'b0;
  logic sck_i = 1'b1, sck_o, sck_oe, txd, rxd = 1'b1;

  sync_serial_xcvr u_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .div_reload(div_reload),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .txd(txd), .rxd(rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [CW-1:0] txq[$], rxsrc[$], rxexp[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int halfp();
    return int'(div_reload) + 1;
  endfunction

  // Internal-mode line monitor, serial-side rx driver and rx consumer
  logic prev_sck = 1'b1, prev_txd = 1'b1;
  int hi_run = 0, lo_run = 0, pulses = 0, gaps = 0, tbit = 0, rbit = 0;
  logic [CW-1:0] tcap = '0, rcur = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = 1'b1; prev_txd = 1'b1;
      hi_run = 0; lo_run = 0; tbit = 0; rbit = 0;
    end else begin
      if (rx_valid && rx_ready) begin
        if (rxexp.size() == 0) chk(1'b0, "R3", "unexpected rx byte", rx_data, 0);
        else begin
          logic [CW-1:0] e;
          e = rxexp.pop_front();
          chk(rx_data == e, "R3 R10", "rx byte", rx_data, e);
        end
      end
      if (!ext_sel) begin
        if (txd != prev_txd && !(prev_sck && !sck_o))
          chk(1'b0, "R2", "txd moved without clock fall", txd, prev_txd);
        if (prev_sck && !sck_o) begin
          if (hi_run != halfp()) gaps++;
          hi_run = 0; lo_run = 1;
          if (rbit == 0) begin
            rcur = (rxsrc.size() != 0) ? rxsrc.pop_front() : 8'h00;
            rxexp.push_back(rcur);
          end
          rxd = rcur[rbit];
          rbit = (rbit + 1) % CW;
        end else if (!prev_sck && sck_o) begin
          chk(lo_run == halfp(), "R4", "low phase length", lo_run, halfp());
          lo_run = 0; hi_run = 1;
          pulses++;
          tcap = {txd, tcap[CW-1:1]};
          tbit++;
          if (tbit == CW) begin
            logic [CW-1:0] e;
            tbit = 0;
            e = (txq.size() != 0) ? txq.pop_front() : 8'hxx;
            chk(tcap == e, "R1", "tx character", tcap, e);
          end
        end else if (sck_o) hi_run++;
        else lo_run++;
      end
      prev_sck = sck_o;
      prev_txd = txd;
    end
  end

  task automatic do_reset(input logic ext);
    @(negedge clk);
    rst_n = 1'b0; ext_sel = ext; sck_i = 1'b1; rxd = 1'b1;
    tx_valid = 1'b0; ovr_clr = 1'b0; rx_ready = 1'b1;
    txq.delete(); rxsrc.delete(); rxexp.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [CW-1:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    txq.push_back(b);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic xfer(input logic [CW-1:0] tb, input logic [CW-1:0] rb);
    rxsrc.push_back(rb);
    send(tb);
  endtask

  task automatic wait_idle();
    int idle = 0;
    while (idle < 4 * halfp() + 8) begin
      @(negedge clk);
      if (sck_o && tx_ready) idle++;
      else idle = 0;
    end
  endtask

  task automatic burst_stats(input int nchar, input string req);
    chk(pulses == CW * nchar, req, "pulse count", pulses, CW * nchar);
    chk(gaps == 1, "R5", "idle gaps in burst", gaps, 1);
    pulses = 0; gaps = 0;
  endtask

  // External clock: one character, bench drives rxd and collects txd
  task automatic ext_char(input logic [CW-1:0] rb, output logic [CW-1:0] got);
    got = '0;
    rxexp.push_back(rb);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk); sck_i = 1'b0; rxd = rb[i];
      repeat (EXT_HALF) @(negedge clk);
      got = {txd, got[CW-1:1]};
      chk(sck_o == 1'b1 && sck_oe == 1'b0, "R9", "pin idle in ext mode",
          {sck_oe, sck_o}, 1);
      sck_i = 1'b1;
      repeat (EXT_HALF) @(negedge clk);
    end
  endtask

  initial begin
    logic [CW-1:0] a, b, c, got, last;
    void'($urandom(32'd20240611));

    // Reset state
    @(negedge clk);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0 && ovr_flag == 1'b0, "R11",
        "flags in reset", {tx_ready, rx_valid, ovr_flag}, 3'b100);
    chk(sck_o == 1'b1 && txd == 1'b1 && sck_oe == 1'b1, "R11",
        "pins in reset", {sck_oe, sck_o, txd}, 3'b111);
    do_reset(1'b0);

    // Single character, N=1
    div_reload = 8'd1; pulses = 0; gaps = 0;
    xfer(8'h5A, 8'h3C);
    wait_idle();
    burst_stats(1, "R4");
    chk(txd == 1'b0, "R2", "txd holds MSB after char", txd, 0);
    chk(sck_o == 1'b1 && sck_oe == 1'b1, "R4", "clock rests high", sck_o, 1);

    // Back-to-back, N=0
    div_reload = 8'd0;
    xfer(8'hC3, 8'h81);
    xfer(8'h17, 8'hFE);
    chk(tx_ready == 1'b0, "R6", "holding full while first shifts", tx_ready, 0);
    chk(pulses < CW, "R6", "second byte taken during first char", pulses, CW);
    xfer(8'hE9, 8'h42);
    wait_idle();
    burst_stats(3, "R5");
    chk(txd == 1'b1, "R2", "txd holds MSB of last char", txd, 1);

    // Random bursts
    for (int k = 0; k < 12; k++) begin
      int len;
      div_reload = DW'($urandom_range(0, 3));
      len = $urandom_range(1, 4);
      for (int j = 0; j < len; j++) begin
        last = CW'($urandom);
        xfer(last, CW'($urandom));
      end
      wait_idle();
      burst_stats(len, "R4");
      chk(txd == last[CW-1], "R2", "random burst MSB hold", txd, last[CW-1]);
    end
    chk(txq.size() == 0 && rxexp.size() == 0, "R10", "all chars both ways",
        txq.size() + rxexp.size(), 0);

    // Receive double buffer: read while next arrives
    div_reload = 8'd2; rx_ready = 1'b0;
    xfer(8'h11, 8'hA1);
    wait_idle();
    chk(rx_valid && rx_data == 8'hA1, "R7", "byte held unread", rx_data, 8'hA1);
    xfer(8'h22, 8'hB2);
    while (pulses < CW + 4) @(negedge clk);
    rx_ready = 1'b1;
    wait_idle();
    chk(ovr_flag == 1'b0, "R7", "no overrun when read in time", ovr_flag, 0);
    pulses = 0; gaps = 0;

    // Overrun
    rx_ready = 1'b0;
    xfer(8'h33, 8'hC4);
    wait_idle();
    xfer(8'h44, 8'hD5);
    wait_idle();
    chk(ovr_flag == 1'b1, "R8", "overrun set", ovr_flag, 1);
    chk(rx_data == 8'hC4, "R8", "old byte kept", rx_data, 8'hC4);
    if (rxexp.size() > 1) rxexp.delete(1);
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0, "R7", "byte consumed", rx_valid, 0);
    xfer(8'h55, 8'hE6);
    wait_idle();
    chk(ovr_flag == 1'b1, "R8", "overrun sticky", ovr_flag, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R8", "overrun cleared", ovr_flag, 0);
    pulses = 0; gaps = 0;

    // External clock mode
    do_reset(1'b1);
    chk(sck_oe == 1'b0 && sck_o == 1'b1, "R9", "clock pin released",
        {sck_oe, sck_o}, 2'b01);
    a = 8'h96; b = 8'h0F; c = 8'h6D;
    send(a);
    send(b);
    repeat (50) @(negedge clk);
    chk(txd == 1'b1, "R9", "txd still with no ext edges", txd, 1);
    ext_char(8'h5C, got);
    chk(got == a, "R9", "ext tx char 1", got, a);
    void'(txq.pop_front());
    ext_char(8'hA3, got);
    chk(got == b, "R9", "ext tx char 2", got, b);
    void'(txq.pop_front());
    repeat (20) @(negedge clk);
    chk(txd == b[CW-1], "R2", "ext txd holds MSB", txd, b[CW-1]);
    send(c);
    ext_char(8'h7E, got);
    chk(got == c, "R1", "ext tx char 3", got, c);
    void'(txq.pop_front());
    repeat (20) @(negedge clk);
    chk(rxexp.size() == 0, "R3", "ext rx bytes delivered", rxexp.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule